// File: doc/BRIEF.md
# SMBus Target with Pointer-Addressed Register Port

This block is a serial-bus target that answers at one fixed 7-bit address and gives a host access to a byte-wide register file through an internal pointer. It samples SCL and SDA with the system clock and finds edges, START and STOP in the sampled levels. It pulls SDA low through an open-drain enable. The register file itself sits outside the block: the block presents the pointer as a register address, takes the selected byte back on a read-data input, and issues a one-cycle write strobe when a write completes.

Three transfer shapes are served. A pointer-only write loads the pointer. A pointer-plus-data write loads the pointer and then writes one register. A read returns the register the pointer currently selects. The host may clock one extra byte to get a CRC-8 packet error code on reads, or to supply one on writes. An idle watchdog drops an open transfer when SCL stops moving. While the alert input is raised, the block also answers the alert response address.

Top module: `smb_target`

## Requirements
- R1: A START followed by address byte 0x98 (7-bit address 1001100, write) or 0x99 (read) is acknowledged by pulling SDA low during the ninth SCL clock. Any other address byte gets no acknowledge, and the block does not drive SDA again until the next START.
- R2: In a write, the first byte after the address loads the pointer, and `reg_addr` then shows that value.
- R3: In a write, the second byte after the address is acknowledged and stored in the register the pointer selects. The write happens when the transfer ends, as exactly one cycle of `reg_we`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R4: After an acknowledged read address, the block shifts out `reg_rdata` for the current pointer, MSB first. It changes SDA only while SCL is low. A read needs no pointer write first.
- R5: When the master does not acknowledge a read byte, the block releases SDA and stays off the bus until the next START. Reset also leaves SDA released.
- R6: If the master acknowledges the read data byte, the next byte is a CRC-8 over the address byte and the data byte (polynomial x^8+x^2+x+1, i.e. 0x07, initial value 0x00, MSB first). Any byte after that reads as 0xFF.
- R7: A third byte in a write is checked against the CRC-8 of the address, pointer and data bytes. If it matches, the byte is acknowledged and the register write goes ahead. If it does not match, the byte is not acknowledged and no register write is made.
- R8: When a transfer is open, `tmo_off` is low, and no SCL edge arrives for TMO_CYCLES clocks, the block releases SDA, returns to idle and discards any pending register write. With `tmo_off` high, the block holds its state for as long as SCL is still.
- R9: While `alert_i` is high, a read to the alert response address (byte 0x19, address 0001100) is acknowledged and answered with 0x98. While `alert_i` is low, the same byte is not acknowledged.
- R10: A repeated START sends the block back to address reception and fixes a new direction. A write that is pending when the repeated START arrives is committed, and the pointer is kept for the next read.
- R11: During reset and right after it, `sda_oe` and `reg_we` are 0 and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| alert_i | input | 1 | Alert condition raised; enables the alert response reply |
| tmo_off | input | 1 | 1 disables the idle watchdog |
| reg_addr | output | 8 | Current pointer, used as register address |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register value at `reg_addr`, read without delay |

## Verification
The assertions take for granted a well-behaved master. SDA changes only while SCL is low, except at START and STOP. Every SCL level lasts several clocks longer than the input synchronizer delay. A STOP is never sent while the block is pulling SDA low. The bench master keeps within these limits. It changes SDA two clocks after each SCL fall, holds each half SCL period for eight clocks, and only stretches SCL low inside acknowledge windows, where the watchdog is the thing being tested.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] CRC_POLY  = 8'h07;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              have_data;
        logic              pec_bad;
    } wr_ctx_t;

    function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] crc,
                                                    input logic [BYTE_W-1:0] din);
        logic [BYTE_W-1:0] c;
        logic              fb;
        c = crc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[BYTE_W-1] ^ din[i];
            c  = {c[BYTE_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
    parameter int unsigned LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run & ~kick & (cnt == LAST);

    // R8: the idle count never passes the limit
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));

    // R8: a stopped or kicked timer restarts from zero
    assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (!run || kick) |=> cnt == '0);
endmodule

// File: rtl/smb_target.sv
module smb_target
    import smb_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h4C,
    parameter logic [6:0]  ARA_ADDR    = 7'h0C,
    parameter int unsigned TMO_CYCLES  = 2500000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              alert_i,
    input  logic              tmo_off,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int LINES = 2;
    localparam int L_SDA = 0;
    localparam int L_SCL = 1;
    localparam logic [3:0] ACK_SLOT = 4'd8;
    localparam logic [BYTE_W-1:0] OWN_BYTE = {DEV_ADDR, 1'b0};

    logic [LINES-1:0] raw, lvl, rse, fll;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[g]),
            .level(lvl[g]),
            .rise (rse[g]),
            .fall (fll[g])
        );
    end

    logic scl_h, sda_h, start_c, stop_c;
    assign scl_h   = lvl[L_SCL];
    assign sda_h   = lvl[L_SDA];
    assign start_c = fll[L_SDA] & scl_h;
    assign stop_c  = rse[L_SDA] & scl_h;

    phase_t            phase;
    logic [3:0]        bitcnt;
    logic [6:0]        shreg;
    logic [BYTE_W-1:0] tx;
    logic [2:0]        bidx;
    logic [BYTE_W-1:0] crc;
    logic [BYTE_W-1:0] ptr;
    wr_ctx_t           wctx;
    logic              ack_pend;
    logic              sda_oe_q;
    logic              we_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              tmo_hit;

    logic [BYTE_W-1:0] byte_in;
    logic [2:0]        bsel;
    logic              commit;
    assign byte_in = {shreg, sda_h};
    assign bsel    = 3'd7 - bitcnt[2:0];
    assign commit  = (phase == PH_WRITE) && wctx.have_data && !wctx.pec_bad;

    smb_idle_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   ((phase != PH_IDLE) && !tmo_off),
        .kick  (rse[L_SCL] | fll[L_SCL]),
        .expire(tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            tx       <= '0;
            bidx     <= '0;
            crc      <= '0;
            ptr      <= '0;
            wctx     <= '0;
            ack_pend <= 1'b0;
            sda_oe_q <= 1'b0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
        end else begin
            we_q <= 1'b0;
            if (tmo_hit) begin
                phase    <= PH_IDLE;
                sda_oe_q <= 1'b0;
            end else if (start_c) begin
                if (commit) begin
                    we_q    <= 1'b1;
                    wdata_q <= wctx.data;
                end
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                bidx     <= '0;
                crc      <= '0;
                ack_pend <= 1'b0;
                sda_oe_q <= 1'b0;
                wctx     <= '0;
            end else if (stop_c) begin
                if (commit) begin
                    we_q    <= 1'b1;
                    wdata_q <= wctx.data;
                end
                phase    <= PH_IDLE;
                sda_oe_q <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (rse[L_SCL]) begin
                    if (bitcnt != ACK_SLOT) begin
                        shreg  <= byte_in[6:0];
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            if (bidx != 3'd7) bidx <= bidx + 3'd1;
                            crc      <= crc8_step(crc, byte_in);
                            ack_pend <= 1'b0;
                            case (phase)
                                PH_ADDR: begin
                                    if (byte_in[7:1] == DEV_ADDR) begin
                                        ack_pend <= 1'b1;
                                        if (byte_in[0]) begin
                                            phase <= PH_READ;
                                            tx    <= reg_rdata;
                                            crc   <= crc8_step(crc8_step(crc, byte_in), reg_rdata);
                                        end else begin
                                            phase <= PH_WRITE;
                                        end
                                    end else if (byte_in == {ARA_ADDR, 1'b1} && alert_i) begin
                                        ack_pend <= 1'b1;
                                        phase    <= PH_READ;
                                        tx       <= OWN_BYTE;
                                        crc      <= crc8_step(crc8_step(crc, byte_in), OWN_BYTE);
                                    end else begin
                                        phase <= PH_SKIP;
                                    end
                                end
                                PH_WRITE: begin
                                    case (bidx)
                                        3'd1: begin
                                            ptr      <= byte_in;
                                            ack_pend <= 1'b1;
                                        end
                                        3'd2: begin
                                            wctx.data      <= byte_in;
                                            wctx.have_data <= 1'b1;
                                            ack_pend       <= 1'b1;
                                        end
                                        3'd3: begin
                                            if (byte_in == crc) ack_pend <= 1'b1;
                                            else wctx.pec_bad <= 1'b1;
                                        end
                                        default: ack_pend <= 1'b0;
                                    endcase
                                end
                                PH_READ: crc <= crc;
                                default: ack_pend <= 1'b0;
                            endcase
                        end
                    end else begin
                        bitcnt <= '0;
                        if (phase == PH_READ && bidx >= 3'd2) begin
                            if (sda_h) phase <= PH_SKIP;
                            else tx <= (bidx == 3'd2) ? crc : FILL_BYTE;
                        end
                    end
                end else if (fll[L_SCL]) begin
                    if (bitcnt == ACK_SLOT) sda_oe_q <= ack_pend;
                    else if (phase == PH_READ) sda_oe_q <= ~tx[bsel];
                    else sda_oe_q <= 1'b0;
                end
            end
        end
    end

    assign sda_oe    = sda_oe_q;
    assign reg_addr  = ptr;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

    // R4: SDA is only ever pulled low while the sampled clock is low
    assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_q) |-> !scl_h);

    // R5: no drive while idle or skipping to the next START
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_oe_q);

    // R3: the register write strobe lasts exactly one cycle
    assert_we_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R7: a register write only ever follows a write transfer
    assert_we_from_write_R7: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(phase) == PH_WRITE);

    // R8: watchdog expiry frees the bus and closes the transfer
    assert_tmo_release_R8: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> (!sda_oe_q && phase == PH_IDLE));

    // R10: a START always lands in address reception
    assert_start_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (start_c && !tmo_hit) |=> phase == PH_ADDR);
endmodule

// File: tb/test_smb_target.sv
module test_smb_target;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int TMO   = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       alert = 1'b0;
    logic       tmo_off = 1'b0;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic       sda_line;

    logic [7:0]  mem     [256];
    logic [7:0]  exp_mem [256];
    logic [15:0] exp_q [$];
    logic        may_drive = 1'b0;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_target #(.TMO_CYCLES(TMO)) i_smb_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .alert_i(alert), .tmo_off(tmo_off), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] crc_add(input logic [7:0] r, input logic [7:0] b);
        logic [7:0] x;
        x = r ^ b;
        for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // register file model and per-clock comparison against expectations
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sda_oe && !may_drive) begin
                total++; bad++;
                $display("FAIL R5 drive outside window act=1 exp=0");
            end
            if (reg_we) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    check("R3 write addr/data", {reg_addr, reg_wdata}, exp_q.pop_front());
                end
                mem[reg_addr] = reg_wdata;
            end
        end
        if (cyc == 150000 && !done) begin
            total++; bad++;
            $display("FAIL R8 watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic bus_start();
        may_drive = 1'b0;
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
        may_drive = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int hold,
                             output logic ack, output logic drv);
        may_drive = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0; tick(2);
        end
        sda_m = 1'b1;
        may_drive = 1'b1;
        tick(HALF + hold);
        drv = sda_oe;
        scl_m = 1'b1; tick(HALF/2);
        ack = ~sda_line; tick(HALF/2);
        scl_m = 1'b0; tick(6);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        may_drive = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl_m = 1'b1; tick(HALF/2);
            b[i] = sda_line; tick(HALF/2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1; tick(4);
        if (!mack) may_drive = 1'b0;
    endtask

    task automatic expect_write(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
        exp_mem[a] = d;
    endtask

    initial begin
        logic ack, drv;
        logic [7:0] d, p;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 3 + 1);
            exp_mem[i] = 8'(i * 3 + 1);
        end
        tick(4);
        check("R11 sda_oe in reset", sda_oe, 0);
        check("R11 reg_we in reset", reg_we, 0);
        rst = 1'b0;
        tick(4);
        check("R11 reg_addr after reset", reg_addr, 8'h00);

        // write byte
        bus_start();
        send_byte(8'h98, 0, ack, drv); check("R1 ack on 0x98", ack, 1);
        send_byte(8'h21, 0, ack, drv); check("R2 ack pointer", ack, 1);
        send_byte(8'h5A, 0, ack, drv); check("R3 ack data", ack, 1);
        expect_write(8'h21, 8'h5A);
        bus_stop(); tick(8);
        check("R2 pointer shown", reg_addr, 8'h21);
        check("R3 write done", exp_q.size(), 0);

        // pointer-only write, then read
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h30, 0, ack, drv); check("R2 send byte ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'h99, 0, ack, drv); check("R1 ack on 0x99", ack, 1);
        recv_byte(1'b0, d); check("R4 read data", d, exp_mem[8'h30]);
        tick(20); check("R5 released after NACK", sda_oe, 0);
        bus_stop();

        // read without pointer write, with PEC and fill byte
        bus_start();
        send_byte(8'h99, 0, ack, drv);
        recv_byte(1'b1, d); check("R4 read again", d, exp_mem[8'h30]);
        recv_byte(1'b1, p); check("R6 read PEC", p, crc_add(crc_add(8'h00, 8'h99), d));
        recv_byte(1'b0, d); check("R6 fill byte", d, 8'hFF);
        bus_stop();

        // write with good PEC
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h40, 0, ack, drv);
        send_byte(8'h11, 0, ack, drv);
        p = crc_add(crc_add(crc_add(8'h00, 8'h98), 8'h40), 8'h11);
        send_byte(p, 0, ack, drv); check("R7 good PEC acked", ack, 1);
        expect_write(8'h40, 8'h11);
        bus_stop(); tick(8);
        check("R7 good PEC write", exp_q.size(), 0);

        // write with bad PEC
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h40, 0, ack, drv);
        send_byte(8'h22, 0, ack, drv);
        p = crc_add(crc_add(crc_add(8'h00, 8'h98), 8'h40), 8'h22) ^ 8'h01;
        send_byte(p, 0, ack, drv); check("R7 bad PEC NACK", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h99, 0, ack, drv);
        recv_byte(1'b0, d); check("R7 register unchanged", d, 8'h11);
        bus_stop();

        // foreign address
        bus_start();
        send_byte(8'hA0, 0, ack, drv); check("R1 foreign address NACK", ack, 0);
        send_byte(8'h55, 0, ack, drv); check("R1 silent after foreign address", ack, 0);
        bus_stop();

        // alert response
        alert = 1'b1;
        bus_start();
        send_byte(8'h19, 0, ack, drv); check("R9 alert response ack", ack, 1);
        recv_byte(1'b0, d); check("R9 own address returned", d, 8'h98);
        bus_stop();
        alert = 1'b0;
        bus_start();
        send_byte(8'h19, 0, ack, drv); check("R9 no alert NACK", ack, 0);
        bus_stop();

        // repeated start
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h50, 0, ack, drv);
        bus_start();
        send_byte(8'h99, 0, ack, drv); check("R10 read after repeated start ack", ack, 1);
        recv_byte(1'b0, d); check("R10 read after repeated start", d, exp_mem[8'h50]);
        bus_stop();
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h51, 0, ack, drv);
        send_byte(8'h77, 0, ack, drv);
        expect_write(8'h51, 8'h77);
        bus_start();
        send_byte(8'h99, 0, ack, drv);
        recv_byte(1'b0, d); check("R10 commit at repeated start", d, 8'h77);
        bus_stop();

        // watchdog enabled: stalled ack is dropped with its write
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h61, 0, ack, drv);
        send_byte(8'h33, 400, ack, drv);
        check("R8 released by watchdog", drv, 0);
        check("R8 no ack after watchdog", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h99, 0, ack, drv);
        recv_byte(1'b0, d); check("R8 write discarded", d, exp_mem[8'h61]);
        bus_stop();

        // watchdog disabled: stalled ack is held
        tmo_off = 1'b1;
        bus_start();
        send_byte(8'h98, 0, ack, drv);
        send_byte(8'h62, 0, ack, drv);
        send_byte(8'h44, 400, ack, drv);
        check("R8 held with watchdog off", drv, 1);
        check("R8 ack with watchdog off", ack, 1);
        expect_write(8'h62, 8'h44);
        bus_stop(); tick(8);
        check("R8 write kept with watchdog off", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule